// File: doc/BRIEF.md
# Function Result Reuse Table

This block remembers the results of completed function calls so that a processor can skip a call it has already made with the same inputs. When a call is about to start, the caller presents a lookup. The lookup carries a function identifier and two argument words. A function that takes only one argument passes zero in the second word. Every stored entry is compared against the lookup at once. One cycle later the block answers. On a hit it raises a skip flag and returns the saved return value, and the caller does not run the function body. On a miss the caller runs the function. When the function finishes, the caller writes the identifier, both arguments and the result back through a separate insert port.

The table is small and fully associative, and each entry carries a valid bit. An insert whose key is already present rewrites that entry in place. Otherwise the insert takes the lowest free entry. When no entry is free, the insert overwrites the entry named by a round-robin pointer. A flush input empties the table in one cycle.

Top module: `fn_reuse_table`

## Requirements
- R1: While reset is high and in the first cycle after it, rsp_valid, rsp_skip and rsp_result are all zero, and the table holds no entries, so the first lookup after reset misses.
- R2: rsp_valid rises exactly one cycle after each cycle in which lk_valid is high, and is low otherwise. On a miss, rsp_skip and rsp_result are zero.
- R3: A lookup whose identifier and both arguments equal those of a stored valid entry gives rsp_skip high and rsp_result equal to that entry's result, one cycle after the lookup.
- R4: A lookup that differs from every stored entry in the identifier, in the first argument or in the second argument misses.
- R5: An insert whose key (identifier plus both arguments) is already stored replaces only that entry's result and uses no further entry.
- R6: An insert of a new key, while some entry is free, occupies the free entry with the lowest index.
- R7: An insert of a new key into a full table overwrites the entry at the round-robin pointer. The pointer then advances by one and wraps from the last entry to entry 0. The pointer is 0 after reset and after a flush, and it moves only on such an overwrite.
- R8: A flush invalidates every entry and resets the pointer at the next edge. An insert presented in the same cycle as a flush is discarded.
- R9: A lookup and an insert in the same cycle give the lookup the contents from before the insert.
- R10: A lookup in the same cycle as a flush is answered from the contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_id | input | ID_W | Function identifier of the lookup |
| lk_arg0 | input | ARG_W | First argument of the lookup |
| lk_arg1 | input | ARG_W | Second argument of the lookup |
| ins_valid | input | 1 | Insert request |
| ins_id | input | ID_W | Function identifier to record |
| ins_arg0 | input | ARG_W | First argument to record |
| ins_arg1 | input | ARG_W | Second argument to record |
| ins_result | input | RES_W | Return value to record |
| rsp_valid | output | 1 | Answer to the lookup of the previous cycle |
| rsp_skip | output | 1 | Previous lookup hit; the call may be skipped |
| rsp_result | output | RES_W | Stored return value on a hit, zero otherwise |

## Verification
A lookup can fall in the same cycle as an insert, and also in the same cycle as a flush. The bench presents a lookup together with an insert of that same new key and expects a miss, then repeats the lookup in the next cycle and expects a hit. It also presents a lookup of a stored key together with a flush and an insert, and expects a hit. It then expects misses afterwards, including for the key that was offered in the flush cycle. A randomized phase over a very small key space causes such collisions often. A behavioural model, which answers every lookup from the contents before the edge, judges each cycle.

// File: rtl/fnr_pkg.sv
package fnr_pkg;
  localparam int FNR_ENTRIES = 8;
  localparam int FNR_ID_W    = 16;
  localparam int FNR_ARG_W   = 32;
  localparam int FNR_RES_W   = 32;

  typedef enum logic [1:0] {
    INS_NONE,
    INS_UPDATE,
    INS_FILL,
    INS_REPLACE
  } fnr_ins_e;
endpackage

// File: rtl/fnr_match.sv
module fnr_match #(
  parameter int ENTRIES = fnr_pkg::FNR_ENTRIES,
  parameter int KEY_W   = 80
) (
  input  logic [KEY_W-1:0]   keys [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  input  logic [KEY_W-1:0]   key,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (keys[g] == key);
  end
endmodule

// File: rtl/fnr_victim.sv
module fnr_victim
  import fnr_pkg::*;
#(
  parameter int ENTRIES = FNR_ENTRIES,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               req,
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [IDX_W-1:0]   rr_ptr,
  output fnr_ins_e           action,
  output logic [IDX_W-1:0]   slot
);
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    action = INS_NONE;
    slot   = rr_ptr;
    if (req) begin
      if (|hit_vec) begin
        action = INS_UPDATE;
        slot   = hit_idx;
      end else if (!(&valid)) begin
        action = INS_FILL;
        slot   = free_idx;
      end else begin
        action = INS_REPLACE;
        slot   = rr_ptr;
      end
    end
  end
endmodule

// File: rtl/fn_reuse_table.sv
module fn_reuse_table
  import fnr_pkg::*;
#(
  parameter int ENTRIES = FNR_ENTRIES,
  parameter int ID_W    = FNR_ID_W,
  parameter int ARG_W   = FNR_ARG_W,
  parameter int RES_W   = FNR_RES_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [ID_W-1:0]  lk_id,
  input  logic [ARG_W-1:0] lk_arg0,
  input  logic [ARG_W-1:0] lk_arg1,
  input  logic             ins_valid,
  input  logic [ID_W-1:0]  ins_id,
  input  logic [ARG_W-1:0] ins_arg0,
  input  logic [ARG_W-1:0] ins_arg1,
  input  logic [RES_W-1:0] ins_result,
  output logic             rsp_valid,
  output logic             rsp_skip,
  output logic [RES_W-1:0] rsp_result
);
  localparam int KEY_W = ID_W + 2 * ARG_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [RES_W-1:0]   res_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]   rr_q;

  logic [KEY_W-1:0]   lk_key, ins_key;
  logic [ENTRIES-1:0] lk_hit_vec, ins_hit_vec;
  logic [RES_W-1:0]   lk_res;
  fnr_ins_e           ins_action;
  logic [IDX_W-1:0]   ins_slot;

  assign lk_key  = {lk_id, lk_arg0, lk_arg1};
  assign ins_key = {ins_id, ins_arg0, ins_arg1};

  fnr_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_lk_match (
    .keys(key_q), .valid(valid_q), .key(lk_key), .hit_vec(lk_hit_vec)
  );

  fnr_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_ins_match (
    .keys(key_q), .valid(valid_q), .key(ins_key), .hit_vec(ins_hit_vec)
  );

  fnr_victim #(.ENTRIES(ENTRIES)) u_victim (
    .req(ins_valid && !flush), .valid(valid_q), .hit_vec(ins_hit_vec),
    .rr_ptr(rr_q), .action(ins_action), .slot(ins_slot)
  );

  // Payload storage: written by index, no reset, read only behind a valid hit.
  always_ff @(posedge clk) begin
    if (ins_action != INS_NONE) begin
      key_q[ins_slot] <= ins_key;
      res_q[ins_slot] <= ins_result;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (ins_action != INS_NONE) begin
      valid_q[ins_slot] <= 1'b1;
      if (ins_action == INS_REPLACE)
        rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
  end

  always_comb begin
    lk_res = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_hit_vec[i]) lk_res = lk_res | res_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_skip   <= 1'b0;
      rsp_result <= '0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_skip   <= lk_valid && (|lk_hit_vec);
      rsp_result <= (lk_valid && (|lk_hit_vec)) ? lk_res : '0;
    end
  end

  AST_RSP_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_skip && rsp_result == '0)); // R1
  AST_SKIP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_skip |-> $past(lk_valid)); // R2
  AST_INSERT_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !flush) ##1 (lk_valid && lk_key == $past(ins_key))
    |=> (rsp_skip && rsp_result == $past(ins_result, 2))); // R3
  AST_KEY_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec) && $onehot0(ins_hit_vec)); // R5
  AST_FILL_FREE: assert property (@(posedge clk) disable iff (rst)
    (ins_action == INS_FILL) |-> !valid_q[ins_slot]); // R6
  AST_REPLACE_FULL: assert property (@(posedge clk) disable iff (rst)
    (ins_action == INS_REPLACE) |-> (&valid_q)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!flush && ins_action != INS_REPLACE) |=> $stable(rr_q)); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(flush) && lk_valid |=> !rsp_skip); // R8
endmodule

// File: tb/fn_reuse_table_bench.sv
module fn_reuse_table_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_id = '0;
  logic [31:0] lk_arg0 = '0, lk_arg1 = '0;
  logic        ins_valid = 1'b0;
  logic [15:0] ins_id = '0;
  logic [31:0] ins_arg0 = '0, ins_arg1 = '0, ins_result = '0;
  logic        rsp_valid, rsp_skip;
  logic [31:0] rsp_result;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fn_reuse_table u_fn_reuse_table (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_valid(lk_valid), .lk_id(lk_id), .lk_arg0(lk_arg0), .lk_arg1(lk_arg1),
    .ins_valid(ins_valid), .ins_id(ins_id), .ins_arg0(ins_arg0),
    .ins_arg1(ins_arg1), .ins_result(ins_result),
    .rsp_valid(rsp_valid), .rsp_skip(rsp_skip), .rsp_result(rsp_result)
  );

  // Behavioural reference
  bit          m_v   [N];
  logic [15:0] m_id  [N];
  logic [31:0] m_a0  [N], m_a1 [N], m_r [N];
  int          m_ptr = 0;
  bit          exp_valid = 0, exp_skip = 0;
  logic [31:0] exp_result = '0;
  string       exp_tag = "R1";

  int checks = 0;
  int fails  = 0;

  function automatic int m_find(input logic [15:0] id, input logic [31:0] a0, a1);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_id[i] == id && m_a0[i] == a0 && m_a1[i] == a1) return i;
    return -1;
  endfunction

  task automatic compare();
    checks++;
    if (rsp_valid !== exp_valid || rsp_skip !== exp_skip || rsp_result !== exp_result) begin
      fails++;
      $display("FAIL %s: got valid=%0b skip=%0b result=%h, expected valid=%0b skip=%0b result=%h",
               exp_tag, rsp_valid, rsp_skip, rsp_result, exp_valid, exp_skip, exp_result);
    end
  endtask

  task automatic step(input bit f, input bit lv, input logic [15:0] lid,
                      input logic [31:0] la0, input logic [31:0] la1,
                      input bit iv, input logic [15:0] iid, input logic [31:0] ia0,
                      input logic [31:0] ia1, input logic [31:0] ir, input string tag);
    int hit, slot;
    @(negedge clk);
    compare();
    flush = f; lk_valid = lv; lk_id = lid; lk_arg0 = la0; lk_arg1 = la1;
    ins_valid = iv; ins_id = iid; ins_arg0 = ia0; ins_arg1 = ia1; ins_result = ir;
    exp_tag = tag;
    if (rst) begin
      exp_valid = 0; exp_skip = 0; exp_result = '0;
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_ptr = 0;
    end else begin
      hit = m_find(lid, la0, la1);
      exp_valid = lv;
      exp_skip  = lv && hit >= 0;
      exp_result = (lv && hit >= 0) ? m_r[hit] : '0;
      if (f) begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_ptr = 0;
      end else if (iv) begin
        slot = m_find(iid, ia0, ia1);
        if (slot < 0)
          for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin
          slot = m_ptr;
          m_ptr = (m_ptr + 1) % N;
        end
        m_v[slot] = 1; m_id[slot] = iid; m_a0[slot] = ia0; m_a1[slot] = ia1; m_r[slot] = ir;
      end
    end
  endtask

  task automatic look(input logic [15:0] id, input logic [31:0] a0, a1, input string tag);
    step(0, 1, id, a0, a1, 0, '0, '0, '0, '0, tag);
  endtask

  task automatic put(input logic [15:0] id, input logic [31:0] a0, a1, r, input string tag);
    step(0, 0, '0, '0, '0, 1, id, a0, a1, r, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, '0, '0, 0, '0, '0, '0, '0, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state and empty table
    for (int i = 0; i < 4; i++) idle("R1");
    rst = 1'b0;
    idle("R1");
    look(16'h1, 32'd10, 32'd20, "R1");
    idle("R1");
    idle("R2");

    // R3 / R4: basic hit and per-field misses
    put(16'h1, 32'd10, 32'd20, 32'd100, "R3");
    look(16'h1, 32'd10, 32'd20, "R3");
    look(16'h2, 32'd10, 32'd20, "R4");
    look(16'h1, 32'd11, 32'd20, "R4");
    look(16'h1, 32'd10, 32'd21, "R4");
    idle("R2");

    // R5: update in place, no extra entry used
    put(16'h1, 32'd10, 32'd20, 32'd200, "R5");
    look(16'h1, 32'd10, 32'd20, "R5");

    // R6: fill the remaining free entries
    for (int k = 1; k < N; k++) put(16'h10 + 16'(k), 32'(k), 32'(k * 3), 32'h1000 + 32'(k), "R6");
    for (int k = 1; k < N; k++) look(16'h10 + 16'(k), 32'(k), 32'(k * 3), "R6");
    look(16'h1, 32'd10, 32'd20, "R5");

    // R7: full table, round-robin from entry 0
    put(16'h30, 32'd1, 32'd1, 32'hAAAA, "R7");
    look(16'h1, 32'd10, 32'd20, "R7");
    look(16'h30, 32'd1, 32'd1, "R7");
    put(16'h31, 32'd2, 32'd2, 32'hBBBB, "R7");
    look(16'h11, 32'd1, 32'd3, "R7");
    look(16'h12, 32'd2, 32'd6, "R7");

    // R9: lookup and insert of the same new key in one cycle
    step(0, 1, 16'h40, 32'd7, 32'd8, 1, 16'h40, 32'd7, 32'd8, 32'hCAFE, "R9");
    look(16'h40, 32'd7, 32'd8, "R9");

    // R10 / R8: flush with lookup and insert in the same cycle
    step(1, 1, 16'h40, 32'd7, 32'd8, 1, 16'h50, 32'd5, 32'd5, 32'h5555, "R10");
    look(16'h40, 32'd7, 32'd8, "R8");
    look(16'h50, 32'd5, 32'd5, "R8");
    look(16'h30, 32'd1, 32'd1, "R8");

    // R8 / R7: pointer restarts at 0 after flush
    for (int k = 0; k < N; k++) put(16'h60 + 16'(k), 32'(k), 32'd0, 32'(k + 1), "R8");
    put(16'h70, 32'd0, 32'd0, 32'h77, "R7");
    look(16'h60, 32'd0, 32'd0, "R7");
    look(16'h61, 32'd1, 32'd0, "R7");
    idle("R2");

    // Randomized mix over a tiny key space
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 23) == 0, $urandom % 2,
           16'($urandom % 3), 32'($urandom % 2), 32'($urandom % 3),
           $urandom % 2, 16'($urandom % 5), 32'($urandom % 2), 32'($urandom % 3),
           $urandom, "R3");
    end
    idle("R2");
    idle("R2");

    summary();
    $finish;
  end
endmodule